// File: doc/BRIEF.md
# Machine Trap Request and Timer Compare Unit

This block is the trap-request logic that sits next to a RISC-V style core. It keeps a free-running 64-bit time counter and a 64-bit compare value that software reaches as two 32-bit control registers. From the time and compare values it derives a timer interrupt. It merges that interrupt with the software and external interrupt lines under the machine enable bits. It also accepts illegal-instruction and breakpoint strobes from the decoder.

When a trap is accepted, the block raises a one-cycle request combinationally. On the next clock edge it loads the cause code and sets a handler flag. While the handler flag is set, every new trap source is held off. The core's return strobe clears the flag. Instruction decode, program-counter redirection and the other control registers stay in the core; the enable bits arrive here as plain inputs.

Top module: `trapUnit`

## Requirements
- R1: After reset, timeValue is 0, the compare value is all ones (both halves read 0xFFFFFFFF), inHandler is 0, trapReq is 0 and trapCause is 0.
- R2: timeValue increases by exactly one on every clock edge after reset is released.
- R3: A write to register address 0x800 replaces bits 31:0 of the compare value, and a write to 0x801 replaces bits 63:32. A read of either address returns that half in the same cycle. A read of any other address returns 0, and a write to any other address leaves both halves unchanged.
- R4: timerPending is 1 exactly when timeValue is greater than or equal to the 64-bit compare value, compared unsigned.
- R5: An interrupt (external, software or timer) is accepted only when its own enable input, globalIe and the inverse of inHandler are all 1.
- R6: When more than one interrupt is accepted in the same cycle, external wins over software, and software wins over timer.
- R7: Illegal-instruction and breakpoint strobes are accepted regardless of any enable input. They take precedence over every interrupt, and illegal-instruction takes precedence over breakpoint.
- R8: While inHandler is 1, trapReq stays 0 for every combination of interrupt lines, enables and exception strobes, and trapCause keeps its value.
- R9: trapCause is loaded on the edge that ends a cycle with trapReq high, and holds its value otherwise. Bit 31 is 1 for an interrupt and 0 for an exception. Bits 3:0 hold the code: 11 external, 3 software, 7 timer, 2 illegal instruction, 3 breakpoint. All other bits are 0.
- R10: inHandler is set on the edge that ends a cycle with trapReq high, and cleared on an edge where retStrobe is high. If both happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Control register write strobe |
| csrAddr | input | 12 | Control register address for read and write |
| csrWrData | input | 32 | Control register write data |
| csrRdData | output | 32 | Control register read data, combinational |
| extIrq | input | 1 | External interrupt line |
| swIrq | input | 1 | Software interrupt line |
| globalIe | input | 1 | Global machine interrupt enable |
| extEn | input | 1 | External interrupt enable |
| swEn | input | 1 | Software interrupt enable |
| timerEn | input | 1 | Timer interrupt enable |
| illegalStrobe | input | 1 | Illegal-instruction strobe from the decoder |
| breakStrobe | input | 1 | Breakpoint strobe from the decoder |
| retStrobe | input | 1 | Return-from-trap strobe |
| trapReq | output | 1 | Trap accepted this cycle |
| trapCause | output | 32 | Cause of the most recently accepted trap |
| inHandler | output | 1 | Handler active flag |
| timerPending | output | 1 | Time has reached the compare value |
| timeValue | output | 64 | Running time counter |

## Verification
A handler flag stuck in the wrong state shows up at the ports within one cycle. It appears either as a trapReq that should have been masked, or as a missing request for a lone enabled source. A wrong priority or cause encoding is visible at trapCause on the edge right after the request. The sweeps cover every combination of sources, enables and the handler state, so no ordering goes unobserved. A compare half written to the wrong place, or a comparison off by one, moves timerPending by at least one cycle. That is caught by the cycle-by-cycle comparison around the crossing point, including the case where only the low half has been written.

// File: rtl/trapPkg.sv
package trapPkg;

  localparam int XLEN = 32;
  localparam int CODE_W = 4;

  // Cause codes, bits 3:0 of the cause value
  localparam logic [CODE_W-1:0] CODE_ILLEGAL = 4'd2;
  localparam logic [CODE_W-1:0] CODE_BREAK   = 4'd3;
  localparam logic [CODE_W-1:0] CODE_SOFT    = 4'd3;
  localparam logic [CODE_W-1:0] CODE_TIMER   = 4'd7;
  localparam logic [CODE_W-1:0] CODE_EXT     = 4'd11;

  // Strobes from control to datapath
  typedef struct packed {
    logic              take;
    logic              isIrq;
    logic [CODE_W-1:0] code;
  } trapStrobe_t;

endpackage

// File: rtl/trapDatapath.sv
module trapDatapath
  import trapPkg::*;
#(
  parameter int W       = XLEN,
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] LO_ADDR = 12'h800,
  parameter logic [ADDR_W-1:0] HI_ADDR = 12'h801
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWrEn,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [W-1:0]      csrWrData,
  output logic [W-1:0]      csrRdData,
  input  trapStrobe_t       strobe,
  output logic [2*W-1:0]    timeValue,
  output logic              timerPending,
  output logic [W-1:0]      trapCause
);

  localparam int TIME_W = 2 * W;
  localparam int HALVES = 2;

  logic [TIME_W-1:0] timeReg;
  logic [W-1:0]      cmpHalf [HALVES];
  logic [W-1:0]      causeReg;
  logic [HALVES-1:0] halfHit;
  logic [TIME_W-1:0] cmpFull;

  // Running time
  always_ff @(posedge clk) begin
    if (!rstN) timeReg <= '0;
    else       timeReg <= timeReg + TIME_W'(1);
  end

  // Compare register halves
  for (genvar h = 0; h < HALVES; h++) begin : g_cmp
    assign halfHit[h] = (csrAddr == ((h == 0) ? LO_ADDR : HI_ADDR));
    always_ff @(posedge clk) begin
      if (!rstN)                      cmpHalf[h] <= '1;
      else if (csrWrEn && halfHit[h]) cmpHalf[h] <= csrWrData;
    end
    assign cmpFull[h*W +: W] = cmpHalf[h];
  end

  always_comb begin
    csrRdData = '0;
    for (int h = 0; h < HALVES; h++)
      if (halfHit[h]) csrRdData = cmpHalf[h];
  end

  assign timerPending = (timeReg >= cmpFull);

  // Cause register
  always_ff @(posedge clk) begin
    if (!rstN)            causeReg <= '0;
    else if (strobe.take) causeReg <= {strobe.isIrq, (W-1)'(strobe.code)};
  end

  assign timeValue = timeReg;
  assign trapCause = causeReg;

  // R2
  time_advances_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (timeReg != $past(timeReg)));

  // R9
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> $stable(causeReg));

  // R9
  cause_code_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> (causeReg[CODE_W-1:0] != '0));

endmodule

// File: rtl/trapControl.sv
module trapControl
  import trapPkg::*;
#(
  parameter int SRC_N = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        extIrq,
  input  logic        swIrq,
  input  logic        timerPending,
  input  logic        globalIe,
  input  logic        extEn,
  input  logic        swEn,
  input  logic        timerEn,
  input  logic        illegalStrobe,
  input  logic        breakStrobe,
  input  logic        retStrobe,
  output logic        trapReq,
  output logic        inHandler,
  output trapStrobe_t strobe
);

  // Interrupt sources, index 0 has the highest priority
  logic [SRC_N-1:0]  srcPend;
  logic [SRC_N-1:0]  srcEn;
  logic [CODE_W-1:0] srcCode [SRC_N];
  logic [SRC_N-1:0]  srcLive;
  logic              handlerReg;
  logic              excTake;
  logic              irqTake;
  logic [CODE_W-1:0] irqCode;

  assign srcPend    = {timerPending, swIrq, extIrq};
  assign srcEn      = {timerEn, swEn, extEn};
  assign srcCode[0] = CODE_EXT;
  assign srcCode[1] = CODE_SOFT;
  assign srcCode[2] = CODE_TIMER;

  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    assign srcLive[s] = srcPend[s] & srcEn[s] & globalIe & ~handlerReg;
  end

  always_comb begin
    irqCode = '0;
    for (int s = SRC_N - 1; s >= 0; s--)
      if (srcLive[s]) irqCode = srcCode[s];
  end

  assign irqTake = |srcLive;
  assign excTake = ~handlerReg & (illegalStrobe | breakStrobe);
  assign trapReq = excTake | irqTake;

  always_comb begin
    strobe.take  = trapReq;
    strobe.isIrq = ~excTake & irqTake;
    if (excTake) strobe.code = illegalStrobe ? CODE_ILLEGAL : CODE_BREAK;
    else         strobe.code = irqCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          handlerReg <= 1'b0;
    else if (trapReq)   handlerReg <= 1'b1;
    else if (retStrobe) handlerReg <= 1'b0;
  end

  assign inHandler = handlerReg;

  // R10
  entry_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> inHandler);

  // R10
  return_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !trapReq) |=> !inHandler);

  // R8
  masked_in_handler_chk: assert property (@(posedge clk) disable iff (!rstN)
    inHandler |-> !trapReq);

  // R6
  ext_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (extIrq && extEn && globalIe && !inHandler && !illegalStrobe && !breakStrobe)
      |-> (trapReq && strobe.code == CODE_EXT && strobe.isIrq));

  // R7
  exc_over_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (illegalStrobe && !inHandler) |-> (trapReq && !strobe.isIrq));

endmodule

// File: rtl/trapUnit.sv
module trapUnit
  import trapPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csrWrEn,
  input  logic [11:0] csrAddr,
  input  logic [31:0] csrWrData,
  output logic [31:0] csrRdData,
  input  logic        extIrq,
  input  logic        swIrq,
  input  logic        globalIe,
  input  logic        extEn,
  input  logic        swEn,
  input  logic        timerEn,
  input  logic        illegalStrobe,
  input  logic        breakStrobe,
  input  logic        retStrobe,
  output logic        trapReq,
  output logic [31:0] trapCause,
  output logic        inHandler,
  output logic        timerPending,
  output logic [63:0] timeValue
);

  trapStrobe_t strobe;

  trapDatapath #(
    .W      (XLEN),
    .ADDR_W (12),
    .LO_ADDR(12'h800),
    .HI_ADDR(12'h801)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .csrWrEn     (csrWrEn),
    .csrAddr     (csrAddr),
    .csrWrData   (csrWrData),
    .csrRdData   (csrRdData),
    .strobe      (strobe),
    .timeValue   (timeValue),
    .timerPending(timerPending),
    .trapCause   (trapCause)
  );

  trapControl #(
    .SRC_N(3)
  ) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .extIrq       (extIrq),
    .swIrq        (swIrq),
    .timerPending (timerPending),
    .globalIe     (globalIe),
    .extEn        (extEn),
    .swEn         (swEn),
    .timerEn      (timerEn),
    .illegalStrobe(illegalStrobe),
    .breakStrobe  (breakStrobe),
    .retStrobe    (retStrobe),
    .trapReq      (trapReq),
    .inHandler    (inHandler),
    .strobe       (strobe)
  );

endmodule

// File: tb/trapUnit_bench.sv
module trapUnit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        csrWrEn;
  logic [11:0] csrAddr;
  logic [31:0] csrWrData;
  logic [31:0] csrRdData;
  logic        extIrq, swIrq, globalIe, extEn, swEn, timerEn;
  logic        illegalStrobe, breakStrobe, retStrobe;
  logic        trapReq;
  logic [31:0] trapCause;
  logic        inHandler;
  logic        timerPending;
  logic [63:0] timeValue;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] lastCause;

  always #(CLK_PERIOD/2) clk = ~clk;

  trapUnit u_trapUnit (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrAddr(csrAddr),
    .csrWrData(csrWrData), .csrRdData(csrRdData), .extIrq(extIrq),
    .swIrq(swIrq), .globalIe(globalIe), .extEn(extEn), .swEn(swEn),
    .timerEn(timerEn), .illegalStrobe(illegalStrobe),
    .breakStrobe(breakStrobe), .retStrobe(retStrobe), .trapReq(trapReq),
    .trapCause(trapCause), .inHandler(inHandler),
    .timerPending(timerPending), .timeValue(timeValue)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    csrWrEn = 0; csrAddr = '0; csrWrData = '0;
    extIrq = 0; swIrq = 0; globalIe = 0; extEn = 0; swEn = 0; timerEn = 0;
    illegalStrobe = 0; breakStrobe = 0; retStrobe = 0;
  endtask

  // Called at a negedge, returns at a negedge
  task automatic csrWrite(input logic [11:0] a, input logic [31:0] d);
    csrWrEn = 1; csrAddr = a; csrWrData = d;
    @(negedge clk);
    csrWrEn = 0; csrAddr = '0; csrWrData = '0;
  endtask

  task automatic csrRead(input logic [11:0] a, output logic [31:0] d);
    csrAddr = a;
    #1;
    d = csrRdData;
    csrAddr = '0;
  endtask

  function automatic logic [32:0] expectTrap(input logic e, input logic s, input logic t,
                                             input logic il, input logic bk, input logic ee,
                                             input logic se, input logic te, input logic g);
    // bit 32 = trap taken, bits 31:0 = cause
    if (il)                return {1'b1, 32'd2};
    if (bk)                return {1'b1, 32'd3};
    if (g && e && ee)      return {1'b1, 32'h8000_000B};
    if (g && s && se)      return {1'b1, 32'h8000_0003};
    if (g && t && te)      return {1'b1, 32'h8000_0007};
    return {1'b0, 32'd0};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] t0;
    logic [63:0] cmpB;
    idleInputs();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // first negedge after release: no rising edge yet with rstN high
    // R1 reset state
    check("R1 time", timeValue, 64'd0);
    check("R1 inHandler", {63'd0, inHandler}, 64'd0);
    check("R1 trapReq", {63'd0, trapReq}, 64'd0);
    check("R1 trapCause", {32'd0, trapCause}, 64'd0);
    csrRead(12'h800, rd); check("R1 cmp low", {32'd0, rd}, 64'h0000_0000_FFFF_FFFF);
    csrRead(12'h801, rd); check("R1 cmp high", {32'd0, rd}, 64'h0000_0000_FFFF_FFFF);
    lastCause = 32'd0;

    // R2 time advances by one per edge
    for (int k = 0; k < 8; k++) begin
      t0 = timeValue;
      @(negedge clk);
      check("R2 increment", timeValue, t0 + 64'd1);
    end

    // R3 readback and foreign-address writes ignored
    csrWrite(12'h800, 32'hA5A5_1234);
    csrWrite(12'h801, 32'h0F0F_5678);
    csrWrite(12'h802, 32'hDEAD_BEEF);
    csrWrite(12'h000, 32'h1111_1111);
    csrRead(12'h800, rd); check("R3 low readback", {32'd0, rd}, 64'hA5A5_1234);
    csrRead(12'h801, rd); check("R3 high readback", {32'd0, rd}, 64'h0F0F_5678);
    csrRead(12'h802, rd); check("R3 other address", {32'd0, rd}, 64'd0);
    csrRead(12'h7FF, rd); check("R3 other address", {32'd0, rd}, 64'd0);

    // R4 high half nonzero keeps the timer quiet
    csrWrite(12'h801, 32'h0000_0001);
    csrWrite(12'h800, 32'h0000_0000);
    for (int k = 0; k < 4; k++) begin
      check("R4 high half set", {63'd0, timerPending}, 64'd0);
      @(negedge clk);
    end

    // R4 crossing point, low half written first, high half still all ones
    csrWrite(12'h801, 32'hFFFF_FFFF);
    t0 = timeValue;
    cmpB = {32'hFFFF_FFFF, t0[31:0] + 32'd12};
    csrWrite(12'h800, cmpB[31:0]);
    check("R4 only low written", {63'd0, timerPending}, 64'd0);
    csrWrite(12'h801, 32'd0);
    cmpB[63:32] = 32'd0;
    for (int k = 0; k < 24; k++) begin
      check("R2 time track", timeValue, t0 + 64'd2 + 64'(k));
      check("R4 compare", {63'd0, timerPending},
            {63'd0, (t0 + 64'd2 + 64'(k)) >= cmpB});
      @(negedge clk);
    end

    // R5 R6 R7 R9 R10 full sweep outside the handler
    for (int tm = 0; tm < 2; tm++) begin
      csrWrite(12'h800, tm ? 32'd0 : 32'hFFFF_FFFF);
      csrWrite(12'h801, tm ? 32'd0 : 32'hFFFF_FFFF);
      check("R4 forced level", {63'd0, timerPending}, 64'(tm));
      for (int c = 0; c < 256; c++) begin
        logic [32:0] ex;
        extIrq = c[0]; swIrq = c[1]; illegalStrobe = c[2]; breakStrobe = c[3];
        extEn = c[4]; swEn = c[5]; timerEn = c[6]; globalIe = c[7];
        ex = expectTrap(c[0], c[1], tm[0], c[2], c[3], c[4], c[5], c[6], c[7]);
        #1;
        check("R5 R6 R7 trapReq", {63'd0, trapReq}, {63'd0, ex[32]});
        @(negedge clk);
        if (ex[32]) lastCause = ex[31:0];
        check("R10 flag set", {63'd0, inHandler}, {63'd0, ex[32]});
        check("R9 cause", {32'd0, trapCause}, {32'd0, lastCause});
        idleInputs();
        retStrobe = 1;
        @(negedge clk);
        retStrobe = 0;
        check("R10 flag cleared", {63'd0, inHandler}, 64'd0);
      end
    end

    // R8 masking sweep inside the handler (timer pending, cmp = 0)
    illegalStrobe = 1;
    @(negedge clk);
    illegalStrobe = 0;
    lastCause = 32'd2;
    check("R10 entered", {63'd0, inHandler}, 64'd1);
    for (int c = 0; c < 256; c++) begin
      extIrq = c[0]; swIrq = c[1]; illegalStrobe = c[2]; breakStrobe = c[3];
      extEn = c[4]; swEn = c[5]; timerEn = c[6]; globalIe = c[7];
      #1;
      check("R8 masked", {63'd0, trapReq}, 64'd0);
      @(negedge clk);
      check("R8 flag kept", {63'd0, inHandler}, 64'd1);
      check("R8 cause kept", {32'd0, trapCause}, {32'd0, lastCause});
    end
    idleInputs();

    // R10 return, then entry and return in the same cycle
    retStrobe = 1;
    @(negedge clk);
    check("R10 return", {63'd0, inHandler}, 64'd0);
    breakStrobe = 1;
    @(negedge clk);
    idleInputs();
    check("R10 entry wins", {63'd0, inHandler}, 64'd1);
    check("R9 break cause", {32'd0, trapCause}, 64'd3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule